// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of an 8-bit successive-approximation converter. After a start strobe it walks a trial code from the most significant bit down to the least. At each step it keeps or drops the current trial bit according to a comparator decision and then raises the next lower bit. Steps are paced in one of two ways, chosen per conversion. The first is a free-running oscillator tick. The second is a step strobe that the serial front end produces from its serial clock.

When the last bit is resolved, the code is written to a result register. A one-cycle completion pulse is raised, and an output shifter is loaded so that the most significant bit appears on the data-out line at once. The serial side then shifts out the remaining bits on later strobes. Chip select only gates the serial-side actions (start and shift), so an oscillator-paced conversion finishes even when chip select is raised.

When a conversion is oscillator-paced, the next start is refused until the fifth bit of the held result has reached data-out. When a conversion is serial-paced, a programmable cycle limit guards against a serial clock that stalls. If the limit is reached, the conversion is aborted and an error flag is raised.

Top module: `sar_conv_engine`

## Requirements
- R1: After reset, busy, done, err, result, trial code and data-out are all 0.
- R2: A start strobe is accepted when chip select is low (cs_n_i = 0), the engine is idle and no read-out hold is pending. In the cycle after acceptance, busy is 1 and the trial code is 0x80.
- R3: Each step replaces the current trial bit (bit 7 first) with cmp_i (1 keeps it) and sets the next lower bit. After 8 steps the resolved code equals the comparator threshold. After the first step the trial code is {cmp, 1, 000000}.
- R4: When osc_mode_i is 1 at acceptance, only osc_tick_i advances the conversion and sclk_step_i has no effect. When osc_mode_i is 0, only sclk_step_i advances it and osc_tick_i has no effect.
- R5: In the cycle after the final step, busy is 0, result_o holds the code, done_o is 1 for exactly one cycle and dout_o shows result bit 7. result_o changes only with done_o.
- R6: Each shift_i strobe with chip select low moves the next lower result bit onto dout_o, and zeros fill in behind.
- R7: While chip select is high, start_i and shift_i are ignored, but the conversion keeps stepping and completes normally.
- R8: After an oscillator-paced conversion completes, starts are refused until three shifts have placed result bit 4 on dout_o.
- R9: In serial-paced mode, if busy lasts longer than tmo_lim_i cycles, the conversion is aborted: busy goes to 0, err_o goes to 1 and no done pulse occurs. The next accepted start clears err_o.
- R10: A start strobe while busy has no effect on the trial code or progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-conversion strobe from the serial side |
| cs_n_i | input | 1 | Active-low chip select; high blocks start and shift |
| osc_mode_i | input | 1 | 1 = oscillator-paced, 0 = serial-paced (sampled at start) |
| osc_tick_i | input | 1 | Internal oscillator tick strobe |
| sclk_step_i | input | 1 | Serial-clock step strobe |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above trial code |
| shift_i | input | 1 | Serial falling-edge strobe that advances data-out |
| tmo_lim_i | input | 16 | Serial-paced busy limit in system cycles |
| trial_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Serial-paced timeout flag |
| result_o | output | 8 | Last resolved code |
| dout_o | output | 1 | Current serial output bit |

## Verification
A bit index that is wrong, or a decision written to the wrong position, shows on trial_o at the next step and in result_o at completion. This is why each vector compares an intermediate trial code as well as the final code. A read-out hold that stays set, or clears too early, shows as a start that is refused or accepted one shift from the expected point, and it is visible on busy_o one cycle after the strobe. A pacing source taken from the wrong input shows as trial_o moving on a strobe that should be ignored. A timeout counter fault shows as err_o rising too early or never rising, within the limit plus one cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_OSC    = 1'b1
    } clk_mode_e;

    // Shifts needed before the middle result bit reaches the output.
    function automatic int ready_shifts(int w);
        return w / 2 - 1;
    endfunction
endpackage

// File: rtl/sar_bit_logic.sv
module sar_bit_logic #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] trial_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             last_o
);
    always_comb begin
        for (int b = 0; b < WIDTH; b++) begin
            if (b == int'(idx_i))
                trial_o[b] = cmp_i;
            else if (int'(idx_i) == b + 1)
                trial_o[b] = 1'b1;
            else
                trial_o[b] = trial_i[b];
        end
        last_o = (idx_i == '0);
    end
endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             hold_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             shift_i,
    output logic             dout_o,
    output logic             ready_o
);
    import sar_pkg::*;
    localparam int READY = ready_shifts(WIDTH);
    localparam int CNT_W = $clog2(WIDTH) + 1;

    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic             hold;
        logic [CNT_W-1:0] cnt;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.sh   = data_i;
            d.hold = hold_i;
            d.cnt  = '0;
        end else if (shift_i) begin
            d.sh = {q.sh[WIDTH-2:0], 1'b0};
            if (q.hold) begin
                d.cnt = q.cnt + 1'b1;
                if (int'(q.cnt) + 1 >= READY)
                    d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout_o  = q.sh[WIDTH-1];
    assign ready_o = !q.hold;
endmodule

// File: rtl/sar_droop_timer.sv
module sar_droop_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [TMO_W-1:0] lim_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (run_i && cnt_q != '1)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = run_i && (cnt_q == lim_i);
endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine #(
    parameter int WIDTH = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cs_n_i,
    input  logic             osc_mode_i,
    input  logic             osc_tick_i,
    input  logic             sclk_step_i,
    input  logic             cmp_i,
    input  logic             shift_i,
    input  logic [TMO_W-1:0] tmo_lim_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [WIDTH-1:0] result_o,
    output logic             dout_o
);
    import sar_pkg::*;
    localparam int IDX_W = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic             busy;
        clk_mode_e        mode;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] trial;
        logic [WIDTH-1:0] result;
        logic             done;
        logic             err;
    } eng_t;

    eng_t d, q;

    logic [WIDTH-1:0] nxt_trial;
    logic             last_step;
    logic             out_ready;
    logic             expire;
    logic             accept;
    logic             step;

    sar_bit_logic #(.WIDTH(WIDTH)) u_bits (
        .trial_i (q.trial),
        .idx_i   (q.idx),
        .cmp_i   (cmp_i),
        .trial_o (nxt_trial),
        .last_o  (last_step)
    );

    sar_out_shift #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (d.done),
        .hold_i  (q.mode == MODE_OSC),
        .data_i  (nxt_trial),
        .shift_i (shift_i && !cs_n_i),
        .dout_o  (dout_o),
        .ready_o (out_ready)
    );

    sar_droop_timer #(.TMO_W(TMO_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (q.busy && q.mode == MODE_SERIAL),
        .clear_i  (accept),
        .lim_i    (tmo_lim_i),
        .expire_o (expire)
    );

    assign accept = start_i && !cs_n_i && !q.busy && out_ready;
    assign step   = q.busy && ((q.mode == MODE_OSC) ? osc_tick_i : sclk_step_i);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (accept) begin
            d.busy  = 1'b1;
            d.mode  = osc_mode_i ? MODE_OSC : MODE_SERIAL;
            d.idx   = IDX_W'(WIDTH - 1);
            d.trial = MSB_ONE;
            d.err   = 1'b0;
        end else if (q.busy) begin
            if (expire) begin
                d.busy  = 1'b0;
                d.err   = 1'b1;
                d.trial = '0;
            end else if (step) begin
                d.trial = nxt_trial;
                d.idx   = q.idx - 1'b1;
                if (last_step) begin
                    d.busy   = 1'b0;
                    d.result = nxt_trial;
                    d.done   = 1'b1;
                    d.trial  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trial_o  = q.trial;
    assign busy_o   = q.busy;
    assign done_o   = q.done;
    assign err_o    = q.err;
    assign result_o = q.result;
endmodule

// File: rtl/sar_conv_engine_chk.sv
module sar_conv_engine_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic [WIDTH-1:0] trial_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [WIDTH-1:0] result_o,
    input logic             dout_o
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    AST_START_MSB_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> trial_o == TOP_BIT); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o)); // R5
    AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o); // R5
    AST_CS_FREEZES_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i && !busy_o |=> $stable(dout_o)); // R7
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o); // R9
endmodule

bind sar_conv_engine sar_conv_engine_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .trial_o  (trial_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .result_o (result_o),
    .dout_o   (dout_o)
);

// File: tb/sar_conv_engine_bench.sv
module sar_conv_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, cs_n = 1'b0, osc_mode = 1'b0;
    logic        tick = 1'b0, sclk = 1'b0, shift = 1'b0;
    logic        cmp;
    logic [15:0] tmo = 16'd1000;
    logic [7:0]  vin = 8'h00;
    logic [7:0]  trial, result;
    logic        busy, done, err, dout;
    int          checks = 0, errors = 0, done_cnt = 0;

    always #4 clk = ~clk;

    assign cmp = (vin >= trial);

    always @(posedge clk) if (done) done_cnt++;

    sar_conv_engine u_sar_conv_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cs_n_i(cs_n),
        .osc_mode_i(osc_mode), .osc_tick_i(tick), .sclk_step_i(sclk),
        .cmp_i(cmp), .shift_i(shift), .tmo_lim_i(tmo),
        .trial_o(trial), .busy_o(busy), .done_o(done), .err_o(err),
        .result_o(result), .dout_o(dout)
    );

    // {osc mode, comparator threshold, expected code}
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 8'hA5, 8'hA5}, {1'b0, 8'h5A, 8'h5A},
        {1'b1, 8'h00, 8'h00}, {1'b0, 8'hFF, 8'hFF},
        {1'b1, 8'h80, 8'h80}, {1'b0, 8'h7F, 8'h7F},
        {1'b1, 8'h01, 8'h01}, {1'b0, 8'hFE, 8'hFE}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask
    task automatic do_start(); start = 1'b1; cyc(); start = 1'b0; endtask
    task automatic do_tick();  tick  = 1'b1; cyc(); tick  = 1'b0; endtask
    task automatic do_sclk();  sclk  = 1'b1; cyc(); sclk  = 1'b0; endtask
    task automatic do_shift(); shift = 1'b1; cyc(); shift = 1'b0; endtask
    task automatic do_step(input logic m); if (m) do_tick(); else do_sclk(); endtask

    task automatic finish_check(input logic [7:0] exp);
        chk("R5 done pulse", done, 1'b1);
        chk("R5 busy low", busy, 1'b0);
        chk("R3 result", result, exp);
        chk("R5 dout msb", dout, exp[7]);
        cyc();
        chk("R5 done one cycle", done, 1'b0);
    endtask

    task automatic read_three(input logic [7:0] exp);
        do_shift(); chk("R6 dout bit6", dout, exp[6]);
        do_shift(); chk("R6 dout bit5", dout, exp[5]);
        do_shift(); chk("R6 dout bit4", dout, exp[4]);
    endtask

    task automatic run_conv(input logic m, input logic [7:0] v, input logic [7:0] exp);
        vin = v; osc_mode = m;
        do_start();
        chk("R2 busy", busy, 1'b1);
        chk("R2 trial msb", trial, 8'h80);
        do_step(m);
        chk("R3 first step", trial, {exp[7], 1'b1, 6'b0});
        for (int s = 1; s < 8; s++) do_step(m);
        finish_check(exp);
        read_three(exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        int dc;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
        chk("R1 result", result, 0); chk("R1 trial", trial, 0); chk("R1 dout", dout, 0);

        for (int i = 0; i < 8; i++) run_conv(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

        // R4: oscillator-paced ignores serial steps
        vin = 8'h3C; osc_mode = 1'b1; do_start();
        repeat (3) do_sclk();
        chk("R4 sclk ignored in osc mode", trial, 8'h80);
        repeat (8) do_tick();
        finish_check(8'h3C); read_three(8'h3C);
        // R4: serial-paced ignores ticks
        vin = 8'hC9; osc_mode = 1'b0; do_start();
        repeat (2) do_tick();
        chk("R4 tick ignored in serial mode", trial, 8'h80);
        repeat (8) do_sclk();
        finish_check(8'hC9); read_three(8'hC9);

        // R10: start while busy has no effect
        vin = 8'hC3; osc_mode = 1'b1; do_start();
        repeat (3) do_tick();
        held = trial;
        do_start();
        chk("R10 trial unchanged", trial, held);
        chk("R10 still busy", busy, 1'b1);
        repeat (5) do_tick();
        finish_check(8'hC3);

        // R8: hold until bit 4 is on dout
        vin = 8'h11; do_start();
        chk("R8 refused with no shifts", busy, 1'b0);
        do_shift(); do_shift();
        do_start();
        chk("R8 refused after two shifts", busy, 1'b0);
        do_shift();
        chk("R8 bit4 on dout", dout, 8'hC3 >> 4 & 1);
        do_start();
        chk("R8 accepted after three shifts", busy, 1'b1);
        repeat (8) do_tick();
        finish_check(8'h11); read_three(8'h11);

        // R7: chip select high does not disturb an oscillator-paced conversion
        vin = 8'h96; do_start();
        repeat (2) do_tick();
        cs_n = 1'b1;
        for (int s = 0; s < 6; s++) begin
            shift = 1'b1; start = 1'b1; tick = 1'b1; cyc();
            shift = 1'b0; start = 1'b0; tick = 1'b0;
        end
        chk("R7 conversion completes with cs high", result, 8'h96);
        chk("R7 dout msb", dout, 1'b1);
        cyc();
        do_shift();
        chk("R7 shift ignored with cs high", dout, 1'b1);
        do_start();
        chk("R7 start ignored with cs high", busy, 1'b0);
        cs_n = 1'b0;
        do_shift();
        chk("R6 shift after cs low", dout, 1'b0);
        do_shift(); do_shift();

        // R9: serial-paced timeout
        tmo = 16'd20; vin = 8'h44; osc_mode = 1'b0;
        dc = done_cnt;
        do_start();
        repeat (10) cyc();
        chk("R9 busy before limit", busy, 1'b1);
        chk("R9 no err before limit", err, 1'b0);
        repeat (20) cyc();
        chk("R9 aborted", busy, 1'b0);
        chk("R9 err set", err, 1'b1);
        chk("R9 no done pulse", done_cnt, dc);
        tmo = 16'd1000;
        do_start();
        chk("R9 err cleared by start", err, 1'b0);
        repeat (8) do_sclk();
        finish_check(8'h44);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule